// File: doc/BRIEF.md
# Multi-Channel Temperature Sampling Controller

This block paces temperature sampling from one on-die sensor and a set of remote sensor channels. A prescaled timer raises a sample strobe at a rate chosen by a two-bit oversampling field. On each strobe the block captures the 10-bit raw code of the channel the mode and channel fields pick. It either publishes that code straight away, or it adds codes into an accumulator and publishes the mean of 2^N of them. Software reads a status word holding the latest result and a valid flag.

Any change to what is being measured makes the current result stale. The measured source, the averaging depth or the bypass choice all count as such a change. The valid flag drops on the next clock and the average starts again from an empty accumulator. Clearing the start bit freezes sampling and keeps the last result. Holding the block in reset or leaving it disabled zeroes everything.

The analog front end is outside the block: each channel's raw code is a plain input. Conversion from code to degrees is also left to software.

Top module: `tsample_ctrl`

## Requirements
- R1: While the synchronous `rst` input is high, or control word 0 has its reset bit (bit 1) set, or its enable bit (bit 2) clear, the status word reads zero one clock later and stays zero.
- R2: The status word carries the result code in bits 9:0, the valid flag in bit 10, and zero in bits 31:11.
- R3: Control word 0 fields: start is bit 0, reset bit 1, enable bit 2, averaging bypass bit 6, channel index bits 16:13, oversampling rate bits 25:24, mode bits 31:30. Control word 1 bits 2:0 hold the averaging exponent N.
- R4: The sample period is PRESCALE·2^rate clocks. After the block starts running, or after a restart, the first sample is taken on the PRESCALE·2^rate-th rising edge.
- R5: Without bypass, the result is the sum of 2^N consecutive samples shifted right by N (truncated). The valid flag is set on the edge of the last sample and not before.
- R6: With bypass set, every sample is published on its own strobe edge, and the exponent has no effect.
- R7: Mode value 2 samples remote channel `index`. Every other mode value samples the on-die sensor and ignores the channel index; changing the index in such a mode neither restarts averaging nor clears the valid flag.
- R8: In mode 2, a channel index at or above NUM_EXT samples the code zero.
- R9: A change of the effective source, of N or of bypass clears the valid flag and the accumulator on the next edge. When this change lands on a strobe edge, that strobe's sample is discarded and the timer restarts.
- R10: With start low, no samples are taken and the status word is held. Raising start again begins a fresh average, timed as in R4.
- R11: The accumulator holds 2^7 samples of the largest code without overflow, so N=7 over all-ones codes yields 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl0_i | input | 32 | Control word 0 (start, reset, enable, bypass, channel, rate, mode) |
| ctrl1_i | input | 32 | Control word 1 (averaging exponent in bits 2:0) |
| int_code_i | input | CODE_W | Raw code of the on-die sensor |
| ext_code_i | input | NUM_EXT·CODE_W | Raw codes of the remote channels, channel k in bits k·CODE_W upward |
| status_o | output | 32 | Result code, valid flag, zero upper bits |

## Verification
A configuration change and a sample strobe can fall on the same rising edge. In that case the block has to restart rather than fold the strobed sample into the new average. The bench completes an average and then counts exactly one sample period forward. It switches from the on-die sensor to a remote channel on the negative edge just before the next strobe. It then checks that the flag is low one cycle later. It also checks that the following average uses only remote-channel samples, with the flag still low one cycle before the second new sample and high right after it.

// File: rtl/tsample_pkg.sv
package tsample_pkg;
  // control word 0 field positions
  localparam int C0_START  = 0;
  localparam int C0_RESET  = 1;
  localparam int C0_ENABLE = 2;
  localparam int C0_BYPASS = 6;
  localparam int C0_CH_LO  = 13;
  localparam int C0_CH_W   = 4;
  localparam int C0_OSR_LO = 24;
  localparam int C0_OSR_W  = 2;
  localparam int C0_MODE_LO = 30;
  localparam int C0_MODE_W  = 2;
  // control word 1
  localparam int C1_EXP_LO = 0;
  localparam int C1_EXP_W  = 3;
  // mode value that routes a remote channel
  localparam logic [1:0] MODE_REMOTE = 2'd2;

  typedef struct packed {
    logic                remote;
    logic [C0_CH_W-1:0]  chan;
    logic [C1_EXP_W-1:0] nexp;
    logic                bypass;
  } cfg_key_t;
endpackage

// File: rtl/tsample_timer.sv
module tsample_timer #(
  parameter int PRESCALE = 4,
  parameter int OSR_W    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             sync_i,
  input  logic [OSR_W-1:0] osr_i,
  output logic             strobe_o
);
  localparam int PER_MAX = PRESCALE << ((1 << OSR_W) - 1);
  localparam int CNT_W   = $clog2(PER_MAX + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit    = (CNT_W'(PRESCALE) << osr_i) - CNT_W'(1);
  assign strobe_o = run_i && !sync_i && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst || sync_i || !run_i) cnt <= '0;
    else if (cnt >= limit)       cnt <= '0;
    else                         cnt <= cnt + CNT_W'(1);
  end

  // R4: after a strobe the period restarts from zero
  a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
    strobe_o |=> (cnt == '0));
  // R10: a halted timer never strobes on the following cycle
  a_r10_no_strobe_halted: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (cnt == '0));
endmodule

// File: rtl/tsample_mux.sv
module tsample_mux #(
  parameter int CODE_W  = 10,
  parameter int NUM_EXT = 4,
  parameter int CH_W    = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      remote_i,
  input  logic [CH_W-1:0]           chan_i,
  input  logic [CODE_W-1:0]         int_code_i,
  input  logic [NUM_EXT*CODE_W-1:0] ext_code_i,
  output logic [CODE_W-1:0]         code_o
);
  logic [CODE_W-1:0] ext_arr [NUM_EXT];

  for (genvar g = 0; g < NUM_EXT; g++) begin : g_unpack
    assign ext_arr[g] = ext_code_i[g*CODE_W +: CODE_W];
  end

  always_comb begin
    code_o = remote_i ? '0 : int_code_i;
    for (int i = 0; i < NUM_EXT; i++) begin
      if (remote_i && chan_i == CH_W'(i)) code_o = ext_arr[i];
    end
  end

  // R8: an index past the last remote channel yields zero
  a_r8_out_of_range: assert property (@(posedge clk) disable iff (rst)
    (remote_i && (32'(chan_i) >= NUM_EXT)) |-> (code_o == '0));
endmodule

// File: rtl/tsample_avg.sv
module tsample_avg #(
  parameter int CODE_W = 10,
  parameter int EXP_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_all_i,
  input  logic              clear_acc_i,
  input  logic              strobe_i,
  input  logic [CODE_W-1:0] sample_i,
  input  logic              bypass_i,
  input  logic [EXP_W-1:0]  nexp_i,
  output logic [CODE_W-1:0] result_o,
  output logic              valid_o
);
  localparam int N_MAX   = (1 << EXP_W) - 1;
  localparam int ACC_W   = CODE_W + N_MAX;
  localparam int CNT_W   = N_MAX;
  localparam int ACC_MAX = ((1 << N_MAX) - 1) * ((1 << CODE_W) - 1);

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] mean;
  logic [CNT_W-1:0] cnt;
  logic             last;

  assign sum  = acc + ACC_W'(sample_i);
  assign mean = sum >> nexp_i;
  assign last = (cnt == CNT_W'((1 << nexp_i) - 1));

  always_ff @(posedge clk) begin
    if (rst || clear_all_i) begin
      acc      <= '0;
      cnt      <= '0;
      result_o <= '0;
      valid_o  <= 1'b0;
    end else if (clear_acc_i) begin
      acc <= '0;
      cnt <= '0;
    end else if (strobe_i) begin
      if (bypass_i) begin
        result_o <= sample_i;
        valid_o  <= 1'b1;
        acc      <= '0;
        cnt      <= '0;
      end else if (last) begin
        result_o <= mean[CODE_W-1:0];
        valid_o  <= 1'b1;
        acc      <= '0;
        cnt      <= '0;
      end else begin
        acc <= sum;
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  // R1: a clear leaves nothing published
  a_r1_cleared: assert property (@(posedge clk) disable iff (rst)
    clear_all_i |=> (!valid_o && result_o == '0));
  // R6: bypass publishes the strobed code itself
  a_r6_bypass: assert property (@(posedge clk) disable iff (rst)
    (strobe_i && bypass_i && !clear_all_i && !clear_acc_i)
      |=> (valid_o && result_o == $past(sample_i)));
  // R11: the running sum stays within its worst-case bound
  a_r11_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (32'(acc) <= ACC_MAX));
endmodule

// File: rtl/tsample_ctrl.sv
module tsample_ctrl
  import tsample_pkg::*;
#(
  parameter int CODE_W   = 10,
  parameter int NUM_EXT  = 4,
  parameter int PRESCALE = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [31:0]               ctrl0_i,
  input  logic [31:0]               ctrl1_i,
  input  logic [CODE_W-1:0]         int_code_i,
  input  logic [NUM_EXT*CODE_W-1:0] ext_code_i,
  output logic [31:0]               status_o
);
  logic                 start, rst_bit, enable, bypass;
  logic [C0_CH_W-1:0]   chan;
  logic [C0_OSR_W-1:0]  osr;
  logic [C0_MODE_W-1:0] mode;
  logic [C1_EXP_W-1:0]  nexp;

  assign start   = ctrl0_i[C0_START];
  assign rst_bit = ctrl0_i[C0_RESET];
  assign enable  = ctrl0_i[C0_ENABLE];
  assign bypass  = ctrl0_i[C0_BYPASS];
  assign chan    = ctrl0_i[C0_CH_LO +: C0_CH_W];
  assign osr     = ctrl0_i[C0_OSR_LO +: C0_OSR_W];
  assign mode    = ctrl0_i[C0_MODE_LO +: C0_MODE_W];
  assign nexp    = ctrl1_i[C1_EXP_LO +: C1_EXP_W];

  logic unused_ctrl_bits;
  assign unused_ctrl_bits = ^{ctrl0_i[29:26], ctrl0_i[23:17], ctrl0_i[12:7],
                              ctrl0_i[5:3], ctrl1_i[31:3]};

  cfg_key_t key_d, key_q;
  logic     hold, run, run_q, run_rise, key_chg, clear_all, sync;
  logic     strobe;
  logic [CODE_W-1:0] sample, result;
  logic     valid;

  always_comb begin
    key_d.remote = (mode == MODE_REMOTE);
    key_d.chan   = key_d.remote ? chan : '0;
    key_d.nexp   = nexp;
    key_d.bypass = bypass;
  end

  assign hold      = rst_bit || !enable;
  assign run       = !hold && start;
  assign run_rise  = run && !run_q;
  assign key_chg   = (key_d != key_q);
  assign clear_all = hold || key_chg;
  assign sync      = clear_all || run_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q <= '0;
      run_q <= 1'b0;
    end else begin
      key_q <= key_d;
      run_q <= run;
    end
  end

  tsample_timer #(.PRESCALE(PRESCALE), .OSR_W(C0_OSR_W)) u_timer (
    .clk(clk), .rst(rst), .run_i(run), .sync_i(sync), .osr_i(osr),
    .strobe_o(strobe));

  tsample_mux #(.CODE_W(CODE_W), .NUM_EXT(NUM_EXT), .CH_W(C0_CH_W)) u_mux (
    .clk(clk), .rst(rst), .remote_i(key_d.remote), .chan_i(chan),
    .int_code_i(int_code_i), .ext_code_i(ext_code_i), .code_o(sample));

  tsample_avg #(.CODE_W(CODE_W), .EXP_W(C1_EXP_W)) u_avg (
    .clk(clk), .rst(rst), .clear_all_i(clear_all), .clear_acc_i(run_rise),
    .strobe_i(strobe), .sample_i(sample), .bypass_i(bypass), .nexp_i(nexp),
    .result_o(result), .valid_o(valid));

  assign status_o = {{(31-CODE_W){1'b0}}, valid, result};

  // R9: a changed source or averaging setup drops the flag
  a_r9_restart: assert property (@(posedge clk) disable iff (rst)
    key_chg |=> !status_o[CODE_W]);
  // R10: halted and untouched, the status word does not move
  a_r10_hold_status: assert property (@(posedge clk) disable iff (rst)
    (!run && !hold && !key_chg) |=> $stable(status_o));
endmodule

// File: tb/tb_tsample_ctrl.sv
module tb_tsample_ctrl;
  localparam int CODE_W   = 10;
  localparam int NUM_EXT  = 4;
  localparam int PRESCALE = 4;

  logic                      clk = 1'b0;
  logic                      rst;
  logic [31:0]               ctrl0, ctrl1;
  logic [CODE_W-1:0]         int_code;
  logic [NUM_EXT*CODE_W-1:0] ext_code;
  logic [31:0]               status;

  int checks = 0;
  int fails  = 0;

  tsample_ctrl #(.CODE_W(CODE_W), .NUM_EXT(NUM_EXT), .PRESCALE(PRESCALE)) dut (
    .clk(clk), .rst(rst), .ctrl0_i(ctrl0), .ctrl1_i(ctrl1),
    .int_code_i(int_code), .ext_code_i(ext_code), .status_o(status));

  always #4 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  function automatic logic [31:0] mk0(input bit st, input bit rb, input bit en,
      input bit byp, input int ch, input int osr, input int mode);
    logic [31:0] w = '0;
    w[0] = st; w[1] = rb; w[2] = en; w[6] = byp;
    w[16:13] = 4'(ch); w[25:24] = 2'(osr); w[31:30] = 2'(mode);
    return w;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive value v on the source chosen by mode/chan, junk elsewhere
  task automatic drive(input int mode, input int chan, input int v);
    int_code = (mode == 2) ? 10'($urandom) : 10'(v);
    for (int i = 0; i < NUM_EXT; i++)
      ext_code[i*CODE_W +: CODE_W] = (mode == 2 && chan == i) ? 10'(v) : 10'($urandom);
  endtask

  // gather samples after a (re)start edge; caller sits on the negedge after it
  task automatic collect(input int mode, input int chan, input int n, input bit byp,
      input int osr, input bit fresh, input int fixv, input string tag);
    int p = PRESCALE << osr;
    int ns = byp ? 1 : (1 << n);
    int sum = 0;
    int v, e;
    for (int k = 0; k < ns; k++) begin
      v = (fixv >= 0) ? fixv : int'($urandom % 1024);
      drive(mode, chan, v);
      sum += (mode == 2 && chan >= NUM_EXT) ? 0 : v;
      if (k == ns - 1) begin
        repeat (p - 1) @(negedge clk);
        if (fresh) chk(status[10] == 1'b0, {tag, " R4 valid early"}, int'(status[10]), 0);
        @(negedge clk);
      end else begin
        repeat (p) @(negedge clk);
      end
    end
    e = byp ? sum : (sum >> n);
    chk(status[10] == 1'b1, {tag, " R5 valid set"}, int'(status[10]), 1);
    chk(int'(status[9:0]) == e, {tag, " result"}, int'(status[9:0]), e);
    chk(status[31:11] == '0, {tag, " R2 upper bits"}, int'(status[31:11]), 0);
  endtask

  task automatic run_avg(input int mode, input int chan, input int n, input int osr,
      input bit byp, input int fixv, input string tag);
    @(negedge clk);
    ctrl0 = '0;
    ctrl1 = 32'(n);
    @(negedge clk);
    ctrl0 = mk0(1, 0, 1, byp, chan, osr, mode);
    drive(mode, chan, 0);
    @(negedge clk);
    collect(mode, chan, n, byp, osr, 1'b1, fixv, tag);
  endtask

  logic [31:0] held;

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; ctrl0 = '0; ctrl1 = '0; int_code = '0; ext_code = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(status == '0, "R1 after reset", int'(status), 0);

    // R5 on-die averaging, R3 field positions
    run_avg(0, 0, 2, 1, 0, -1, "R5 internal N2");
    run_avg(2, 1, 1, 0, 0, -1, "R7 remote ch1");
    run_avg(1, 9, 1, 0, 0, -1, "R7 mode1 internal");
    run_avg(2, 7, 0, 0, 0, -1, "R8 index past end");
    run_avg(2, 3, 3, 2, 1, -1, "R6 bypass");
    collect(2, 3, 3, 1, 2, 1'b0, -1, "R6 bypass second");
    run_avg(0, 0, 7, 0, 0, 1023, "R11 N7 full scale");

    // R7 index change in internal mode keeps result
    run_avg(0, 0, 1, 0, 0, -1, "R7 base");
    held = status;
    ctrl0 = mk0(1, 0, 1, 0, 3, 0, 0);
    @(negedge clk);
    chk(status == held, "R7 index ignored", int'(status), int'(held));
    ctrl0 = mk0(1, 0, 1, 0, 5, 0, 3);
    @(negedge clk);
    chk(status == held, "R7 mode3 same source", int'(status), int'(held));

    // R9 change coinciding with a strobe edge
    run_avg(0, 0, 1, 0, 0, -1, "R9 base");
    repeat (PRESCALE - 1) @(negedge clk);
    ctrl0 = mk0(1, 0, 1, 0, 1, 0, 2);
    drive(2, 1, 0);
    @(negedge clk);
    chk(status[10] == 1'b0, "R9 flag cleared on collision", int'(status[10]), 0);
    collect(2, 1, 1, 0, 0, 1'b1, -1, "R9 after collision");

    // R10 halt keeps status, change while halted clears, resume restarts
    run_avg(2, 2, 1, 0, 0, -1, "R10 base");
    held = status;
    ctrl0 = mk0(0, 0, 1, 0, 2, 0, 2);
    for (int i = 0; i < 3 * PRESCALE; i++) begin
      drive(2, 2, int'($urandom % 1024));
      @(negedge clk);
    end
    chk(status == held, "R10 halted status held", int'(status), int'(held));
    ctrl0 = mk0(0, 0, 1, 0, 0, 0, 2);
    @(negedge clk);
    chk(status[10] == 1'b0, "R9 change while halted", int'(status[10]), 0);
    ctrl0 = mk0(1, 0, 1, 0, 0, 0, 2);
    @(negedge clk);
    collect(2, 0, 1, 0, 0, 1'b1, -1, "R10 resume");

    // R1 reset bit zeroes status
    ctrl0 = mk0(1, 1, 1, 0, 0, 0, 2);
    @(negedge clk);
    chk(status == '0, "R1 reset bit", int'(status), 0);

    // random trials for R4 and R5
    for (int t = 0; t < 10; t++) begin
      run_avg(int'($urandom % 4), int'($urandom % 5), int'($urandom % 4),
              int'($urandom % 4), 1'b0, -1, "R4 R5 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule